// File: doc/BRIEF.md
# Periodic Slotted Frame Transmitter

This block sits on the head side of a shared multidrop serial bus. A free-running timer starts one four-byte frame every fixed period, whether or not any data is waiting. The frame goes out as a byte stream to a UART transmitter through a ready/valid handshake. Each frame holds an 8-bit header and two data bytes. These 24 bits are spread over the six upper bits of four byte symbols. The two low bits of every symbol hold the symbol's position (0 to 3), so a receiver can place any byte without first locking onto the frame.

Two byte-stream sources feed the frame: a high-priority channel A and a low-priority channel B. Each source marks the last byte of a packet. A frame carries at most two bytes, all from one channel. The header token gives the number of valid data bytes. A packet ends when its channel sends token 0, so the frame after a packet's last byte is forced to token 0 on that channel. When a data slot is unused, the last data byte carries a free-buffer credit. The credit is looked up from a per-position table for the frame's tap address.

The tap address names the drop that may answer in this frame. It steps round-robin over drop positions 1 to 31. A one-cycle clear strobe replaces the next frame's tap with 0, which tells every drop to zero its frame counter.

The controller has four states:
- `ST_WAIT`: idle until the period tick.
- `ST_TAKE0`: pick the channel and tap, and maybe accept the first byte.
- `ST_TAKE1`: maybe accept the second byte.
- `ST_SEND`: hand out the four symbols.

Its transitions are:
- `ST_WAIT` to `ST_TAKE0` on a tick or a tick latched while the previous frame was busy.
- `ST_TAKE0` to `ST_TAKE1` always.
- `ST_TAKE1` to `ST_SEND` always.
- `ST_SEND` to `ST_WAIT` after the fourth accepted symbol.

Top module: `tslot_frame_tx`

## Requirements
- R1: With the UART always ready, the first symbols of consecutive frames are exactly PERIOD clock cycles apart, with or without data.
- R2: Symbol k of a frame (k = 0..3) has k in bits 1:0. Bits 7:2 of symbol k carry bits 6k+5..6k of the 24-bit word {data1, data0, header}, with bit 0 as the LSB.
- R3: The header holds the token (valid data byte count, 0 to 2) in bits 1:0, the channel in bit 2 (0 = A, 1 = B) and the tap address in bits 7:3.
- R4: At a packet boundary, channel A is chosen over channel B whenever A offers a byte.
- R5: A frame accepts up to two bytes, both from its own channel. Accepting a byte marked last stops loading for that frame. A byte is accepted only when its channel's valid is high. The two channel readies are never high together.
- R6: The frame after a frame that carried a packet's last byte has token 0 on that packet's channel and accepts no data.
- R7: With token 1, data1 is the credit of the frame's tap position. With token 0, data0 is 0 and data1 is that credit. The credit of position p is `credit_in[8p+7:8p]`.
- R8: The tap address starts at 1 after reset, advances by one each frame, and wraps from 31 back to 1.
- R9: A pulse on `clr_req` makes the next frame carry tap 0. The rotation pauses, and the frame after that carries the tap that was skipped.
- R10: While a packet is open on one channel and that channel has no byte, the frame is sent on the other channel with token 0. The open packet is not ended, and no byte is taken from the other channel.
- R11: During reset, `tx_valid`, `a_ready` and `b_ready` are low.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Channel A byte offered |
| a_data | input | 8 | Channel A byte |
| a_last | input | 1 | Channel A byte ends its packet |
| a_ready | output | 1 | Channel A byte accepted this cycle |
| b_valid | input | 1 | Channel B byte offered |
| b_data | input | 8 | Channel B byte |
| b_last | input | 1 | Channel B byte ends its packet |
| b_ready | output | 1 | Channel B byte accepted this cycle |
| clr_req | input | 1 | Request one tap-0 counter-clear frame |
| credit_in | input | NUM_POS*8 | Free-buffer credit per bus position |
| tx_valid | output | 1 | Symbol offered to the UART |
| tx_data | output | 8 | Frame symbol |
| tx_ready | input | 1 | UART accepts the symbol |

## Verification
A table walk feeds several packets at once:
- a three-byte channel A packet, which tells a two-byte frame from a one-byte frame that ends a packet;
- a one-byte channel B packet behind it, which shows that A wins and that both channels get their token-0 closing frame;
- an empty-queue tail, which shows the idle frame with its credit.

Directed runs then cover further patterns:
- A packet whose next byte arrives late, which separates a mid-packet idle frame (token 0 on the other channel) from a real packet end.
- Long idle stretches that walk the tap through its wrap and across a clear pulse, which shows the pause in the rotation.
- A toggling UART ready, which shows the frame contents do not depend on back-pressure.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

    localparam int TAP_W   = 5;
    localparam int BYTE_W  = 8;
    localparam int SYM_N   = 4;
    localparam int TAG_W   = 2;
    localparam int PAY_W   = BYTE_W - TAG_W;
    localparam int FLAT_W  = SYM_N * PAY_W;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_TAKE0,
        ST_TAKE1,
        ST_SEND
    } tx_state_e;

    typedef enum logic [1:0] {
        OWN_NONE,
        OWN_A,
        OWN_B
    } owner_e;

    typedef struct packed {
        logic [TAP_W-1:0] tap;
        logic             chan;
        logic [1:0]       token;
    } hdr_t;

endpackage

// File: rtl/tslot_period_timer.sv
module tslot_period_timer #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/tslot_tap_seq.sv
module tslot_tap_seq #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             clr_req,
    output logic [TAP_W-1:0] tap
);
    localparam logic [TAP_W-1:0] FIRST = TAP_W'(1);
    localparam logic [TAP_W-1:0] LAST  = {TAP_W{1'b1}};

    logic [TAP_W-1:0] ptr;
    logic             clr_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= FIRST;
            clr_pend <= 1'b0;
        end else begin
            clr_pend <= (clr_pend && !advance) || clr_req;
            if (advance && !clr_pend)
                ptr <= (ptr == LAST) ? FIRST : ptr + 1'b1;
        end
    end

    assign tap = clr_pend ? '0 : ptr;
endmodule

// File: rtl/tslot_frame_packer.sv
module tslot_frame_packer
    import tslot_pkg::*;
(
    input  hdr_t                        hdr,
    input  logic [BYTE_W-1:0]           d0,
    input  logic [BYTE_W-1:0]           d1,
    output logic [SYM_N-1:0][BYTE_W-1:0] word
);
    logic [FLAT_W-1:0] flat;

    assign flat = {d1, d0, hdr};

    for (genvar k = 0; k < SYM_N; k++) begin : g_sym
        assign word[k] = {flat[k*PAY_W +: PAY_W], TAG_W'(k)};
    end
endmodule

// File: rtl/tslot_frame_tx.sv
module tslot_frame_tx
    import tslot_pkg::*;
#(
    parameter int PERIOD  = 1000,
    parameter int NUM_POS = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    a_valid,
    input  logic [7:0]              a_data,
    input  logic                    a_last,
    output logic                    a_ready,
    input  logic                    b_valid,
    input  logic [7:0]              b_data,
    input  logic                    b_last,
    output logic                    b_ready,
    input  logic                    clr_req,
    input  logic [NUM_POS*8-1:0]    credit_in,
    output logic                    tx_valid,
    output logic [7:0]              tx_data,
    input  logic                    tx_ready
);
    localparam int IDX_W = $clog2(SYM_N);

    tx_state_e         state, state_n;
    owner_e            owner;
    logic              eop_pend, eop_ch;
    logic              tick, tick_pend;
    logic              sel_b, take;
    logic              cur_last;
    logic [7:0]        cur_data;
    logic [TAP_W-1:0]  tap_cur;
    logic [7:0]        credit_cur;
    logic [IDX_W-1:0]  byte_idx;
    logic              more_q;
    hdr_t              hdr_q;
    logic [7:0]        d0_q, d1_q;
    logic [SYM_N-1:0][7:0] word;

    tslot_period_timer #(.PERIOD(PERIOD)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tslot_tap_seq #(.TAP_W(TAP_W)) i_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (state == ST_TAKE0),
        .clr_req (clr_req),
        .tap     (tap_cur)
    );

    tslot_frame_packer i_pack (
        .hdr  (hdr_q),
        .d0   (d0_q),
        .d1   (d1_q),
        .word (word)
    );

    assign credit_cur = credit_in[{tap_cur, 3'b000} +: 8];
    assign cur_data   = sel_b ? b_data : a_data;
    assign cur_last   = sel_b ? b_last : a_last;

    // channel choice and byte acceptance
    always_comb begin
        sel_b = 1'b0;
        take  = 1'b0;
        if (state == ST_TAKE0) begin
            if (eop_pend) begin
                sel_b = eop_ch;
            end else begin
                unique case (owner)
                    OWN_A: begin
                        sel_b = !a_valid;
                        take  = a_valid;
                    end
                    OWN_B: begin
                        sel_b = b_valid;
                        take  = b_valid;
                    end
                    default: begin
                        if (a_valid) begin
                            take = 1'b1;
                        end else if (b_valid) begin
                            sel_b = 1'b1;
                            take  = 1'b1;
                        end
                    end
                endcase
            end
        end else if (state == ST_TAKE1) begin
            sel_b = hdr_q.chan;
            take  = more_q && (hdr_q.chan ? b_valid : a_valid);
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_WAIT:  if (tick || tick_pend) state_n = ST_TAKE0;
            ST_TAKE0: state_n = ST_TAKE1;
            ST_TAKE1: state_n = ST_SEND;
            ST_SEND:  if (tx_ready && byte_idx == IDX_W'(SYM_N - 1)) state_n = ST_WAIT;
            default:  state_n = ST_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_n;
    end

    // frame assembly registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner     <= OWN_NONE;
            eop_pend  <= 1'b0;
            eop_ch    <= 1'b0;
            tick_pend <= 1'b0;
            more_q    <= 1'b0;
            byte_idx  <= '0;
            hdr_q     <= '0;
            d0_q      <= '0;
            d1_q      <= '0;
        end else begin
            if (state == ST_WAIT)  tick_pend <= 1'b0;
            else if (tick)         tick_pend <= 1'b1;

            unique case (state)
                ST_TAKE0: begin
                    hdr_q.chan  <= sel_b;
                    hdr_q.tap   <= tap_cur;
                    hdr_q.token <= 2'd0;
                    d0_q        <= '0;
                    d1_q        <= credit_cur;
                    more_q      <= 1'b0;
                    if (take) begin
                        hdr_q.token <= 2'd1;
                        d0_q        <= cur_data;
                        if (cur_last) begin
                            eop_pend <= 1'b1;
                            eop_ch   <= sel_b;
                            owner    <= OWN_NONE;
                        end else begin
                            owner  <= sel_b ? OWN_B : OWN_A;
                            more_q <= 1'b1;
                        end
                    end else if (eop_pend) begin
                        eop_pend <= 1'b0;
                    end
                end
                ST_TAKE1: begin
                    if (take) begin
                        hdr_q.token <= 2'd2;
                        d1_q        <= cur_data;
                        if (cur_last) begin
                            eop_pend <= 1'b1;
                            eop_ch   <= sel_b;
                            owner    <= OWN_NONE;
                        end
                    end
                end
                ST_SEND: begin
                    if (tx_ready) byte_idx <= byte_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        a_ready  = take && !sel_b;
        b_ready  = take && sel_b;
        tx_valid = (state == ST_SEND);
        tx_data  = word[byte_idx];
    end
endmodule

// File: rtl/tslot_frame_tx_chk.sv
module tslot_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       a_valid,
    input logic       a_ready,
    input logic       b_valid,
    input logic       b_ready,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_ready
);
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    a_r2_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_data[1:0] != 2'd3
        |=> tx_valid && tx_data[1:0] == $past(tx_data[1:0]) + 2'd1);

    a_r2_first_tag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_data[1:0] == 2'd0);

    a_r3_token_max: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_data[1:0] == 2'd0 |-> tx_data[3:2] != 2'b11);

    a_r5_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_ready, b_ready}));

    a_r5_a_offered: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |-> a_valid);

    a_r5_b_offered: assert property (@(posedge clk) disable iff (!rst_n)
        b_ready |-> b_valid);
endmodule

bind tslot_frame_tx tslot_frame_tx_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_valid  (a_valid),
    .a_ready  (a_ready),
    .b_valid  (b_valid),
    .b_ready  (b_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready)
);

// File: tb/test_tslot_frame_tx.sv
module test_tslot_frame_tx;
    localparam int P   = 40;
    localparam int NP  = 32;
    localparam int MAXF = 128;

    typedef struct packed {
        logic [1:0] tok;
        logic       ch;
        logic [4:0] tap;
        logic [7:0] d0;
        logic [7:0] d1;
    } exp_t;

    localparam exp_t VEC [6] = '{
        '{2'd2, 1'b0, 5'd1, 8'h11, 8'h22},
        '{2'd1, 1'b0, 5'd2, 8'h33, 8'h42},
        '{2'd0, 1'b0, 5'd3, 8'h00, 8'h43},
        '{2'd1, 1'b1, 5'd4, 8'hA5, 8'h44},
        '{2'd0, 1'b1, 5'd5, 8'h00, 8'h45},
        '{2'd0, 1'b0, 5'd6, 8'h00, 8'h46}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_req = 1'b0;
    logic tx_ready = 1'b1;
    logic [NP*8-1:0] credit_in;
    logic a_valid, a_last, a_ready, b_valid, b_last, b_ready, tx_valid;
    logic [7:0] a_data, b_data, tx_data;

    logic [7:0] a_mem [0:15];
    logic       a_lm  [0:15];
    logic [7:0] b_mem [0:15];
    logic       b_lm  [0:15];
    int a_len = 0, b_len = 0, a_idx, b_idx;

    logic [7:0] fr_b [0:MAXF-1][0:3];
    int fr_cyc [0:MAXF-1];
    int nfr = 0, bi = 0, cyc = 0;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    assign a_valid = a_idx < a_len;
    assign a_data  = a_mem[a_idx[3:0]];
    assign a_last  = a_lm[a_idx[3:0]];
    assign b_valid = b_idx < b_len;
    assign b_data  = b_mem[b_idx[3:0]];
    assign b_last  = b_lm[b_idx[3:0]];

    tslot_frame_tx #(.PERIOD(P), .NUM_POS(NP)) i_tslot_frame_tx (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_data(a_data), .a_last(a_last), .a_ready(a_ready),
        .b_valid(b_valid), .b_data(b_data), .b_last(b_last), .b_ready(b_ready),
        .clr_req(clr_req), .credit_in(credit_in),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    // source models and frame capture
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            a_idx <= 0;
            b_idx <= 0;
        end else begin
            if (a_valid && a_ready) a_idx <= a_idx + 1;
            if (b_valid && b_ready) b_idx <= b_idx + 1;
            if (tx_valid && tx_ready && nfr < MAXF) begin
                fr_b[nfr][bi] = tx_data;
                if (bi == 0) fr_cyc[nfr] = cyc;
                if (bi == 3) begin
                    bi = 0;
                    nfr = nfr + 1;
                end else begin
                    bi = bi + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] flat_of(input int k);
        logic [23:0] f;
        for (int i = 0; i < 4; i++) f[i*6 +: 6] = fr_b[k][i][7:2];
        return f;
    endfunction

    task automatic check_frame(input int k, input exp_t e, input string req);
        logic [23:0] f;
        exp_t got;
        bit tags;
        f = flat_of(k);
        got = {f[1:0], f[2], f[7:3], f[15:8], f[23:16]};
        tags = 1'b1;
        for (int i = 0; i < 4; i++) if (fr_b[k][i][1:0] != 2'(i)) tags = 1'b0;
        check(tags, "R2 tags", k, 0);
        check(got == e, req, int'(got), int'(e));
    endtask

    task automatic wait_frames(input int n);
        while (nfr < n) @(negedge clk);
    endtask

    task automatic push_a(input logic [7:0] d, input logic l);
        a_mem[a_len] = d; a_lm[a_len] = l; a_len++;
    endtask

    task automatic push_b(input logic [7:0] d, input logic l);
        b_mem[b_len] = d; b_lm[b_len] = l; b_len++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) credit_in[i*8 +: 8] = 8'(8'h40 + i);
        push_a(8'h11, 1'b0); push_a(8'h22, 1'b0); push_a(8'h33, 1'b1);
        push_b(8'hA5, 1'b1);
        repeat (3) @(negedge clk);
        check(!tx_valid && !a_ready && !b_ready, "R11 reset quiet",
              {tx_valid, a_ready, b_ready}, 0);
        rst_n = 1'b1;

        // R3 R4 R5 R6 R7: table walk over the preloaded packets
        wait_frames(6);
        for (int k = 0; k < 6; k++) check_frame(k, VEC[k], "R3 R4 R5 R6 R7 table");

        // R8: idle frames walk the tap to 31 then wrap to 1
        wait_frames(32);
        check_frame(30, '{2'd0, 1'b0, 5'd31, 8'h00, 8'h5F}, "R8 tap 31");
        check_frame(31, '{2'd0, 1'b0, 5'd1, 8'h00, 8'h41}, "R8 wrap to 1");

        // R9: clear strobe inserts tap 0 and pauses the rotation
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        wait_frames(34);
        check_frame(32, '{2'd0, 1'b0, 5'd0, 8'h00, 8'h40}, "R9 tap 0");
        check_frame(33, '{2'd0, 1'b0, 5'd2, 8'h00, 8'h42}, "R9 resume");

        // R10: open A packet stalls, B waits, idle frame goes out on B
        push_a(8'h55, 1'b0);
        push_b(8'h77, 1'b1);
        wait_frames(36);
        push_a(8'h66, 1'b1);
        wait_frames(40);
        check_frame(34, '{2'd1, 1'b0, 5'd3, 8'h55, 8'h43}, "R4 R7 A first");
        check_frame(35, '{2'd0, 1'b1, 5'd4, 8'h00, 8'h44}, "R10 idle on B");
        check_frame(36, '{2'd1, 1'b0, 5'd5, 8'h66, 8'h45}, "R10 packet resumes");
        check_frame(37, '{2'd0, 1'b0, 5'd6, 8'h00, 8'h46}, "R6 end A");
        check_frame(38, '{2'd1, 1'b1, 5'd7, 8'h77, 8'h47}, "R5 B packet");
        check_frame(39, '{2'd0, 1'b1, 5'd8, 8'h00, 8'h48}, "R6 end B");

        // R1: fixed spacing while the UART is always ready
        begin
            bit ok = 1'b1;
            int bad = 0;
            for (int k = 1; k < 40; k++)
                if (fr_cyc[k] - fr_cyc[k-1] != P) begin
                    ok = 1'b0;
                    bad = fr_cyc[k] - fr_cyc[k-1];
                end
            check(ok, "R1 period", bad, P);
        end

        // R12: back-pressure leaves frame contents intact
        push_a(8'h81, 1'b0); push_a(8'h82, 1'b1);
        while (nfr < 42) begin
            @(negedge clk);
            tx_ready = ~tx_ready;
        end
        tx_ready = 1'b1;
        check_frame(40, '{2'd2, 1'b0, 5'd9, 8'h81, 8'h82}, "R12 R5 two bytes");
        check_frame(41, '{2'd0, 1'b0, 5'd10, 8'h00, 8'h4A}, "R12 R6 end");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule